// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one compare channel of an event timer. It watches a free-running counter value that is shared among channels and counted somewhere else. When the global run enable is high and the counter equals the channel's live compare value, the channel records a hit. It sets a status flag and can drive an interrupt line, either as a one-cycle pulse or as a level that stays up until software clears it.

The channel has two modes. In one-shot mode hardware never touches the compare value, and software may rewrite it at any time. In periodic mode the channel keeps a separate period register holding the last value that software wrote. On every hit it adds that period to the live compare value, so the channel re-arms itself without help from software. Routing the interrupt to a controller and producing the counter are not part of this block.

Top module: `evt_cmp_channel`

## Requirements
- R1: After synchronous reset the configuration readback is 0x10, the compare and period readbacks are 0, and irq_o and sts_o are 0.
- R2: The configuration word has writable bits at level select (bit 1, 1 = level), interrupt enable (bit 2) and periodic mode (bit 3). Bit 4 always reads 1 to report that periodic mode is supported. Every other bit reads 0.
- R3: A compare write loads both the live compare value and the stored period, and both are visible on the readbacks the cycle after the write.
- R4: While run_i is low no hit occurs: status does not set and the compare value does not change.
- R5: In one-shot mode (bit 3 = 0) a hit (run_i high and cnt_i equal to the compare value) sets status and leaves the compare value unchanged.
- R6: In periodic mode a hit replaces the compare value with the compare value plus the stored period, modulo 2^CNT_W.
- R7: In edge mode (bit 1 = 0) with interrupts enabled, irq_o is high for exactly the one cycle after each hit.
- R8: In level mode with interrupts enabled, irq_o rises the cycle after a hit and stays high until a status clear. A hit in the same cycle as a clear leaves status set.
- R9: With interrupt enable low, irq_o stays low, but a hit still sets status.
- R10: A compare write in the same cycle as a periodic hit takes precedence over the re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Global enable; matches are evaluated only while high |
| cnt_i | input | CNT_W | Shared counter value |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value write data |
| sts_clr_i | input | 1 | Clear the status flag |
| cfg_rd_o | output | CFG_W | Configuration readback |
| cmp_rd_o | output | CNT_W | Live compare value |
| per_rd_o | output | CNT_W | Stored period |
| sts_o | output | 1 | Hit status flag |
| irq_o | output | 1 | Interrupt output, pulse or level |

## Verification
The bench builds the channel with CNT_W = 16 and CFG_W = 8. With a 16-bit width the bench can place the compare value near the top of the range, so a single re-arm addition overflows and the modular wrap of R6 is observable. The bench drives the counter value itself rather than counting. This lets it jump straight to a matching value, hold it for a run_i-low cycle, and align a hit with a compare write or a status clear in the same cycle.

// File: rtl/cmpch_pkg.sv
package cmpch_pkg;
  localparam int unsigned CFG_LVL_BIT = 1;
  localparam int unsigned CFG_IEN_BIT = 2;
  localparam int unsigned CFG_PER_BIT = 3;
  localparam int unsigned CFG_CAP_BIT = 4;

  typedef struct packed {
    logic periodic;
    logic ien;
    logic level;
  } ch_cfg_t;
endpackage

// File: rtl/cmpch_cfg.sv
module cmpch_cfg
  import cmpch_pkg::*;
#(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output ch_cfg_t          cfg_o,
  output logic [CFG_W-1:0] rd_o
);
  ch_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.level    <= wdata_i[CFG_LVL_BIT];
      cfg_q.ien      <= wdata_i[CFG_IEN_BIT];
      cfg_q.periodic <= wdata_i[CFG_PER_BIT];
    end
  end

  always_comb begin
    rd_o              = '0;
    rd_o[CFG_LVL_BIT] = cfg_q.level;
    rd_o[CFG_IEN_BIT] = cfg_q.ien;
    rd_o[CFG_PER_BIT] = cfg_q.periodic;
    rd_o[CFG_CAP_BIT] = 1'b1;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cmpch_arm.sv
module cmpch_arm #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             periodic_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0] per_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] rearm;

  assign hit_o = run_i && (cnt_i == cmp_q);
  assign rearm = cmp_q + per_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      per_q <= '0;
    end else if (we_i) begin
      cmp_q <= wdata_i;
      per_q <= wdata_i;
    end else if (hit_o && periodic_i) begin
      cmp_q <= rearm;
    end
  end

  assign cmp_o = cmp_q;
  assign per_o = per_q;
endmodule

// File: rtl/cmpch_irq.sv
module cmpch_irq
  import cmpch_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    hit_i,
  input  logic    clr_i,
  input  ch_cfg_t cfg_i,
  output logic    sts_o,
  output logic    irq_o
);
  logic sts_q;
  logic sts_d;
  logic irq_q;

  assign sts_d = (sts_q && !clr_i) || hit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq_q <= cfg_i.ien && (cfg_i.level ? sts_d : hit_i);
    end
  end

  assign sts_o = sts_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import cmpch_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             sts_clr_i,
  output logic [CFG_W-1:0] cfg_rd_o,
  output logic [CNT_W-1:0] cmp_rd_o,
  output logic [CNT_W-1:0] per_rd_o,
  output logic             sts_o,
  output logic             irq_o
);
  ch_cfg_t cfg;
  logic    hit;

  cmpch_cfg #(.CFG_W(CFG_W)) i_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg), .rd_o(cfg_rd_o)
  );

  cmpch_arm #(.CNT_W(CNT_W)) i_arm (
    .clk(clk), .rst(rst), .run_i(run_i), .cnt_i(cnt_i),
    .periodic_i(cfg.periodic), .we_i(cmp_we_i), .wdata_i(cmp_wdata_i),
    .cmp_o(cmp_rd_o), .per_o(per_rd_o), .hit_o(hit)
  );

  cmpch_irq i_irq (
    .clk(clk), .rst(rst), .hit_i(hit), .clr_i(sts_clr_i), .cfg_i(cfg),
    .sts_o(sts_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/evt_cmp_channel_chk.sv
module evt_cmp_channel_chk #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned CFG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cmp_we_i,
  input logic [CNT_W-1:0] cmp_wdata_i,
  input logic             sts_clr_i,
  input logic [CFG_W-1:0] cfg_rd_o,
  input logic [CNT_W-1:0] cmp_rd_o,
  input logic [CNT_W-1:0] per_rd_o,
  input logic             irq_o
);
  assert_write_loads_R3: assert property (@(posedge clk) disable iff (rst)
    cmp_we_i |=> (cmp_rd_o == $past(cmp_wdata_i)) && (per_rd_o == $past(cmp_wdata_i)));

  assert_halt_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !cmp_we_i) |=> $stable(cmp_rd_o));

  assert_oneshot_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rd_o[3] && !cmp_we_i) |=> $stable(cmp_rd_o));

  assert_rearm_add_R6: assert property (@(posedge clk) disable iff (rst)
    (run_i && (cnt_i == cmp_rd_o) && cfg_rd_o[3] && !cmp_we_i)
      |=> (cmp_rd_o == CNT_W'($past(cmp_rd_o) + $past(per_rd_o))));

  assert_level_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_o && cfg_rd_o[1] && cfg_rd_o[2] && !sts_clr_i) |=> irq_o);

  assert_ien_gates_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd_o[2] |=> !irq_o);
endmodule

bind evt_cmp_channel evt_cmp_channel_chk #(.CNT_W(CNT_W), .CFG_W(CFG_W)) i_chk (
  .clk(clk), .rst(rst), .run_i(run_i), .cnt_i(cnt_i), .cmp_we_i(cmp_we_i),
  .cmp_wdata_i(cmp_wdata_i), .sts_clr_i(sts_clr_i), .cfg_rd_o(cfg_rd_o),
  .cmp_rd_o(cmp_rd_o), .per_rd_o(per_rd_o), .irq_o(irq_o)
);

// File: tb/test_evt_cmp_channel.sv
module test_evt_cmp_channel;
  localparam int unsigned W  = 16;
  localparam int unsigned CW = 8;
  localparam int unsigned NV = 8;

  // vector: {cnt[15:0], run, exp_irq, exp_cmp[15:0]}
  localparam logic [33:0] VEC [NV] = '{
    {16'd3,  1'b1, 1'b0, 16'd5},
    {16'd5,  1'b1, 1'b1, 16'd10},
    {16'd6,  1'b1, 1'b0, 16'd10},
    {16'd10, 1'b0, 1'b0, 16'd10},
    {16'd10, 1'b1, 1'b1, 16'd15},
    {16'd15, 1'b1, 1'b1, 16'd20},
    {16'd16, 1'b1, 1'b0, 16'd20},
    {16'd20, 1'b1, 1'b1, 16'd25}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_i = 1'b0;
  logic [W-1:0]  cnt_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [CW-1:0] cfg_wdata_i = '0;
  logic          cmp_we_i = 1'b0;
  logic [W-1:0]  cmp_wdata_i = '0;
  logic          sts_clr_i = 1'b0;
  logic [CW-1:0] cfg_rd_o;
  logic [W-1:0]  cmp_rd_o;
  logic [W-1:0]  per_rd_o;
  logic          sts_o;
  logic          irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_cmp_channel #(.CNT_W(W), .CFG_W(CW)) i_evt_cmp_channel (
    .clk(clk), .rst(rst), .run_i(run_i), .cnt_i(cnt_i), .cfg_we_i(cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i), .cmp_we_i(cmp_we_i), .cmp_wdata_i(cmp_wdata_i),
    .sts_clr_i(sts_clr_i), .cfg_rd_o(cfg_rd_o), .cmp_rd_o(cmp_rd_o),
    .per_rd_o(per_rd_o), .sts_o(sts_o), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(logic [CW-1:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v; tick(); cfg_we_i = 1'b0;
  endtask

  task automatic wr_cmp(logic [W-1:0] v);
    cmp_we_i = 1'b1; cmp_wdata_i = v; tick(); cmp_we_i = 1'b0;
  endtask

  task automatic clear_sts();
    sts_clr_i = 1'b1; tick(); sts_clr_i = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 cfg", 32'(cfg_rd_o), 32'h10);
    check("R1 cmp", 32'(cmp_rd_o), 0);
    check("R1 per", 32'(per_rd_o), 0);
    check("R1 irq/sts", {30'd0, irq_o, sts_o}, 0);

    // R2 configuration readback
    wr_cfg(8'hFF);
    check("R2 cfg all ones", 32'(cfg_rd_o), 32'h1E);
    wr_cfg(8'h00);
    check("R2 cfg zero", 32'(cfg_rd_o), 32'h10);

    // R3 periodic edge mode setup
    wr_cfg(8'h0C);
    cnt_i = 16'd1;
    wr_cmp(16'd5);
    check("R3 cmp", 32'(cmp_rd_o), 5);
    check("R3 per", 32'(per_rd_o), 5);

    // R6 R7 R4 vector walk
    foreach (VEC[i]) begin
      cnt_i = VEC[i][33:18];
      run_i = VEC[i][17];
      tick();
      check($sformatf("R6/R7 vec%0d irq", i), 32'(irq_o), 32'(VEC[i][16]));
      check($sformatf("R6/R4 vec%0d cmp", i), 32'(cmp_rd_o), 32'(VEC[i][15:0]));
    end

    // R8 one-shot level mode
    run_i = 1'b0;
    wr_cfg(8'h06);
    wr_cmp(16'h40);
    clear_sts();
    check("R8 cleared", {30'd0, irq_o, sts_o}, 0);
    run_i = 1'b1; cnt_i = 16'h40; tick();
    check("R5 sts", 32'(sts_o), 1);
    check("R5 cmp unchanged", 32'(cmp_rd_o), 32'h40);
    check("R8 irq rise", 32'(irq_o), 1);
    cnt_i = 16'h41; tick();
    check("R8 irq held", 32'(irq_o), 1);
    sts_clr_i = 1'b1; cnt_i = 16'h42; tick();
    check("R8 irq after clear", {30'd0, irq_o, sts_o}, 0);
    cnt_i = 16'h40; tick();
    check("R8 hit beats clear", {30'd0, irq_o, sts_o}, 3);
    sts_clr_i = 1'b0; cnt_i = 16'h41;

    // R9 interrupt enable low
    run_i = 1'b0;
    wr_cfg(8'h02);
    clear_sts();
    run_i = 1'b1; cnt_i = 16'h40; tick();
    check("R9 sts set irq low", {30'd0, irq_o, sts_o}, 1);

    // R4 no hit while halted
    run_i = 1'b0;
    clear_sts();
    tick();
    check("R4 halted sts", 32'(sts_o), 0);
    check("R4 halted cmp", 32'(cmp_rd_o), 32'h40);

    // R6 wrap
    cnt_i = 16'h0;
    wr_cfg(8'h08);
    wr_cmp(16'hFFF0);
    run_i = 1'b1; cnt_i = 16'hFFF0; tick();
    check("R6 wrap", 32'(cmp_rd_o), 32'hFFE0);

    // R10 write beats re-arm
    cnt_i = 16'hFFE0; cmp_we_i = 1'b1; cmp_wdata_i = 16'h0100; tick();
    cmp_we_i = 1'b0; run_i = 1'b0;
    check("R10 cmp", 32'(cmp_rd_o), 32'h100);
    check("R10 per", 32'(per_rd_o), 32'h100);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule